// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the load-linked reservations of a cache and decides the outcome of every store-conditional. The cache controller reports each completed access as one event: the cache line address, the ID of the requester, an access kind and a flag that says whether the line is resident in the cache. The monitor answers every event one cycle later with a response strobe and a success bit. The core uses the bit as the result of a store-conditional: 1 means the store took place, 0 means it failed.

Reservations live in a small table of locked lines. Each entry holds a line address and the ID of the requester that owns the lock. A load-linked sets the lock on its line for its requester. Every store-conditional removes the lock on its line, whether it succeeds or not. An ordinary store from the lock's owner also removes the lock. A separate port reports that the cache has lost coherence permission on a line, and this drops the affected requester's lock. A mode input can switch the monitor off. While it is off, every access reports success.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A load-linked event (kind code 0) always responds with success. Afterwards the line is locked for the event's requester ID, which replaces any earlier owner of that line. At most one table entry holds a given line.
- R2: A store-conditional event (kind code 1) responds 1 only when its line is locked by the same requester ID. Otherwise it responds 0.
- R3: Every store-conditional removes the lock on its line, whether it succeeds or fails and whoever owns the lock. A second store-conditional to that line therefore responds 0.
- R4: An ordinary store (kind code 2) or a read-modify-write store (kind code 3) always responds 1. It removes the lock on its line only when the lock belongs to the event's requester ID. A store from another ID leaves the lock in place.
- R5: An event whose line is not resident responds 1 and leaves every lock unchanged.
- R6: A permission-loss report removes the lock on the reported line if the reported requester owns it. The report is processed after the completion event of the same cycle, so a load-linked and a loss report on the same line in the same cycle leave the line unlocked.
- R7: While the mode input is low, every event responds 1 and no completion event changes a lock. Permission-loss reports still take effect.
- R8: A load-linked to a line that has no entry takes the lowest-numbered free entry. When the table is full, it replaces entries in round-robin order. The round-robin pointer starts at entry 0 and advances only when it is used.
- R9: The response strobe is high for exactly one cycle, in the cycle after each completion event. It stays low after reset and after a cycle with only a loss report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_en | input | 1 | 1 = monitor active, 0 = every access reports success |
| ev_valid | input | 1 | A completion event is present |
| ev_kind | input | 2 | 0 load-linked, 1 store-conditional, 2 store, 3 read-modify-write store |
| ev_line | input | LINE_W | Cache line address of the event |
| ev_id | input | ID_W | Requester ID of the event |
| ev_present | input | 1 | The line is resident in the cache |
| loss_valid | input | 1 | A coherence permission loss is reported |
| loss_line | input | LINE_W | Line that lost permission |
| loss_id | input | ID_W | Requester whose reservation is dropped |
| rsp_valid | output | 1 | Response strobe, one cycle per event |
| rsp_ok | output | 1 | Success bit, valid with rsp_valid |

## Verification
A wrong lock entry stays hidden until a store-conditional reads it. It then appears as a flipped success bit on the cycle after that store-conditional. The bench therefore follows every kind of lock change with store-conditionals to the same lines. It uses a small pool of line addresses, so random traffic keeps hitting locked lines. A wrong replacement choice only appears after the table has filled and an evicted or surviving line is then probed. A directed sequence does this, and the random stream does it repeatedly.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    K_LL  = 2'd0,
    K_SC  = 2'd1,
    K_ST  = 2'd2,
    K_RMW = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/llsc_cam.sv
module llsc_cam #(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 8,
  parameter int ID_W    = 2
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [LINE_W-1:0]  lines  [ENTRIES],
  input  logic [ID_W-1:0]    owners [ENTRIES],
  input  logic [LINE_W-1:0]  key_line,
  input  logic [ID_W-1:0]    key_id,
  input  logic               check_owner,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (lines[i] == key_line) &&
                        (!check_owner || (owners[i] == key_id));
  end
endmodule

// File: rtl/llsc_victim.sv
module llsc_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic [IDX_W-1:0]   victim,
  output logic               use_rr
);
  always_comb begin
    victim = rr_ptr;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        victim = IDX_W'(i);
        use_rr = 1'b0;
      end
    end
  end
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 8,
  parameter int ID_W    = 2,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_en,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [LINE_W-1:0] ev_line,
  input  logic [ID_W-1:0]   ev_id,
  input  logic              ev_present,
  input  logic              loss_valid,
  input  logic [LINE_W-1:0] loss_line,
  input  logic [ID_W-1:0]   loss_id,
  output logic              rsp_valid,
  output logic              rsp_ok
);
  logic [ENTRIES-1:0] ent_v;
  logic [LINE_W-1:0]  ent_line  [ENTRIES];
  logic [ID_W-1:0]    ent_owner [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] line_hit, own_hit;
  logic [IDX_W-1:0]   victim;
  logic               use_rr;

  llsc_cam #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) u_line_cam (
    .valid(ent_v), .lines(ent_line), .owners(ent_owner),
    .key_line(ev_line), .key_id(ev_id), .check_owner(1'b0), .hit_vec(line_hit));

  llsc_cam #(.ENTRIES(ENTRIES), .LINE_W(LINE_W), .ID_W(ID_W)) u_own_cam (
    .valid(ent_v), .lines(ent_line), .owners(ent_owner),
    .key_line(ev_line), .key_id(ev_id), .check_owner(1'b1), .hit_vec(own_hit));

  llsc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid(ent_v), .rr_ptr(rr_ptr), .victim(victim), .use_rr(use_rr));

  acc_kind_e kind;
  logic      act, is_ll, is_sc, is_wr, line_any, alloc;
  assign kind     = acc_kind_e'(ev_kind);
  assign act      = ev_valid && mon_en && ev_present;
  assign is_ll    = act && (kind == K_LL);
  assign is_sc    = act && (kind == K_SC);
  assign is_wr    = act && ((kind == K_ST) || (kind == K_RMW));
  assign line_any = |line_hit;
  assign alloc    = is_ll && !line_any;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              nv;
    logic [LINE_W-1:0] nl;
    logic [ID_W-1:0]   no;
    always_comb begin
      nv = ent_v[i];
      nl = ent_line[i];
      no = ent_owner[i];
      if (is_ll && line_hit[i]) no = ev_id;
      if (alloc && (victim == IDX_W'(i))) begin
        nv = 1'b1;
        nl = ev_line;
        no = ev_id;
      end
      if (is_sc && line_hit[i]) nv = 1'b0;
      if (is_wr && own_hit[i])  nv = 1'b0;
      if (loss_valid && (nl == loss_line) && (no == loss_id)) nv = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_v[i]     <= 1'b0;
        ent_line[i]  <= '0;
        ent_owner[i] <= '0;
      end else begin
        ent_v[i]     <= nv;
        ent_line[i]  <= nl;
        ent_owner[i] <= no;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr    <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      if (alloc && use_rr)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      rsp_valid <= ev_valid;
      rsp_ok    <= ev_valid && (!is_sc || (|own_hit));
    end
  end

  // R1: one entry per line
  p_line_unique_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(line_hit));
  // R1: load-linked always succeeds
  p_ll_ok_r1: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == 2'd0) |=> rsp_ok);
  // R2: store-conditional success needs an own lock
  p_sc_needs_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !(|own_hit)) |=> !rsp_ok);
  // R5: absent line reports success
  p_absent_ok_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_present) |=> rsp_ok);
  // R7: disabled monitor reports success
  p_disabled_ok_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !mon_en) |=> rsp_ok);
  // R9: strobe follows an event by one cycle
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ev_valid));
  // R9: no success bit without the strobe
  p_ok_gated_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |-> rsp_valid);
endmodule

// File: tb/sim_llsc_resv_monitor.sv
module sim_llsc_resv_monitor;
  localparam int N = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic mon_en = 1'b1, ev_valid = 1'b0, ev_present = 1'b1, loss_valid = 1'b0;
  logic [1:0] ev_kind = 2'd0;
  logic [7:0] ev_line = '0, loss_line = '0;
  logic [1:0] ev_id = '0, loss_id = '0;
  logic rsp_valid, rsp_ok;
  int total = 0, bad = 0;
  bit m_v [N];
  int m_l [N], m_o [N], m_rr;

  always #5 clk = ~clk;

  llsc_resv_monitor #(.ENTRIES(N), .LINE_W(8), .ID_W(2)) u0 (
    .clk(clk), .rst(rst), .mon_en(mon_en), .ev_valid(ev_valid), .ev_kind(ev_kind),
    .ev_line(ev_line), .ev_id(ev_id), .ev_present(ev_present),
    .loss_valid(loss_valid), .loss_line(loss_line), .loss_id(loss_id),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_step(int k, int ln, int id, bit pres, bit en,
                                    bit lv, int lln, int lid, bit ev);
    int res = 1, h = -1, slot = -1;
    if (ev && en && pres) begin
      for (int i = 0; i < N; i++) if (m_v[i] && m_l[i] == ln) h = i;
      if (k == 0) begin
        if (h >= 0) m_o[h] = id;
        else begin
          for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
          if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
          m_v[slot] = 1; m_l[slot] = ln; m_o[slot] = id;
        end
      end else if (k == 1) begin
        res = (h >= 0 && m_o[h] == id) ? 1 : 0;
        if (h >= 0) m_v[h] = 0;
      end else if (h >= 0 && m_o[h] == id) m_v[h] = 0;
    end
    if (lv) for (int i = 0; i < N; i++)
      if (m_v[i] && m_l[i] == lln && m_o[i] == lid) m_v[i] = 0;
    return res;
  endfunction

  // drive at negedge, response registered at next posedge, sampled at following negedge
  task automatic op(input string req, input int k, input int ln, input int id,
                    input bit pres = 1, input bit en = 1,
                    input bit lv = 0, input int lln = 0, input int lid = 0);
    int exp;
    ev_valid = 1; ev_kind = k[1:0]; ev_line = ln[7:0]; ev_id = id[1:0];
    ev_present = pres; mon_en = en;
    loss_valid = lv; loss_line = lln[7:0]; loss_id = lid[1:0];
    exp = model_step(k, ln, id, pres, en, lv, lln, lid, 1'b1);
    @(negedge clk);
    ev_valid = 0; loss_valid = 0; mon_en = 1;
    check({req, " strobe"}, rsp_valid, 1);
    check(req, rsp_ok, exp);
  endtask

  task automatic loss_only(input string req, input int lln, input int lid);
    int unused;
    loss_valid = 1; loss_line = lln[7:0]; loss_id = lid[1:0];
    unused = model_step(0, 0, 0, 1, 1, 1'b1, lln, lid, 1'b0);
    @(negedge clk);
    loss_valid = 0;
    check(req, rsp_valid, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_l[i] = 0; m_o[i] = 0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R9 reset strobe", rsp_valid, 0);
    check("R9 reset ok", rsp_ok, 0);
    op("R2 sc unlocked", 1, 1, 0);
    op("R1 ll", 0, 1, 0);
    op("R2 sc locked", 1, 1, 0);
    op("R3 second sc", 1, 1, 0);
    op("R1 ll b", 0, 2, 0);
    op("R2 sc other id", 1, 2, 1);
    op("R3 sc after failed sc", 1, 2, 0);
    op("R1 ll c", 0, 3, 0);
    op("R4 store other id", 2, 3, 1);
    op("R4 sc lock kept", 1, 3, 0);
    op("R1 ll c2", 0, 3, 0);
    op("R4 rmw own id", 3, 3, 0);
    op("R4 sc after own store", 1, 3, 0);
    op("R1 ll d", 0, 4, 0);
    op("R5 sc absent", 1, 4, 0, 0);
    op("R5 sc lock kept", 1, 4, 0);
    op("R5 ll absent", 0, 9, 1, 0);
    op("R5 sc after absent ll", 1, 9, 1);
    op("R1 ll e", 0, 5, 0);
    loss_only("R9 loss only no strobe", 5, 0);
    op("R6 sc after loss", 1, 5, 0);
    op("R6 ll with same-cycle loss", 0, 6, 0, 1, 1, 1, 6, 0);
    op("R6 sc after ll+loss", 1, 6, 0);
    op("R1 ll f", 0, 8, 1);
    loss_only("R6 loss wrong id", 8, 0);
    op("R6 sc lock survives", 1, 8, 1);
    op("R7 sc disabled", 1, 7, 0, 1, 0);
    op("R7 ll disabled", 0, 7, 0, 1, 0);
    op("R7 sc after disabled ll", 1, 7, 0);
    op("R8 fill0", 0, 10, 0);
    op("R8 fill1", 0, 11, 0);
    op("R8 fill2", 0, 12, 0);
    op("R8 fill3", 0, 13, 0);
    op("R8 evict rr", 0, 14, 0);
    op("R8 evicted line", 1, 10, 0);
    op("R8 free entry", 1, 12, 0);
    op("R8 ll into free", 0, 15, 0);
    op("R8 survivor", 1, 11, 0);
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int k = $urandom % 4, ln = $urandom % 6, id = $urandom % 2;
      bit pres = ($urandom % 10) != 0, en = ($urandom % 10) != 0;
      bit lv = ($urandom % 7) == 0;
      int lln = $urandom % 6, lid = $urandom % 2;
      op("R2 R4 random", k, ln, id, pres, en, lv, lln, lid);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule